// File: doc/BRIEF.md
# Multi-Mode State Variable Filter

This block is a fixed-point state variable filter for audio samples. It keeps two integrator states, a band-pass state and a low-pass state. From these it derives a high-pass value and a notch value, and it presents one of the four responses on its output. All products go through a single 18x18 signed multiplier. A short step sequencer shares that multiplier across the damping, band-pass and low-pass products for each sample. The multiplier has registered operands and a combinational product, so the product of one step is consumed in the next step.

The surrounding system supplies a new sample together with a one-cycle `start` strobe. It also supplies a frequency coefficient `coef_f` and a damping coefficient `coef_q`. Both coefficients are in Q1.17 format, so 131072 stands for 1.0. `coef_f` is roughly 2·π·Fc/Fs, and `coef_q` is the reciprocal of the quality factor, so Q can go no lower than 1. Even at Q = 1 the response peaks near the cutoff frequency. A high Q, or a large `coef_f`, can drive the internal values past the output range. For this reason every response is clipped to the 18-bit range, and a sticky flag reports that clipping happened.

Four clock edges after the start is taken, the block updates `y_out` and raises `done` for one cycle. The internal accumulators are `ACC_W` bits wide and wrap around on overflow. Only the responses taken from them are clipped.

Top module: `svf_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, both integrator states, the high-pass register, `y_out`, `done` and `ovf` become zero, and the step sequencer returns to idle.
- R2: A `start` that is high at an edge where the block is idle is accepted, and `x_in` is latched at that edge. `done` is high for exactly one cycle, just after the fourth edge counted from that acceptance. A `start` that is high in that `done` cycle is accepted.
- R3: A `start` that is high at any of the three edges after an acceptance is ignored. The values of `x_in` and `mode` at those edges have no effect on the result.
- R4: The high-pass value is hp = sat(((2^18·x − q·bp_old − z2) mod 2^ACC_W) >>> 17). Here bp_old = sat(z1 >>> 17) is taken before the update, and z2 is the low-pass state.
- R5: After hp is computed, z1 becomes z1 + f·hp. Then z2 becomes z2 + f·sat(z1 >>> 17), using the new z1. Both sums wrap at `ACC_W` bits. The responses are lp = sat(z2 >>> 17), bp = sat(z1 >>> 17), hp, and notch = sat((z2 >>> 17) + hp).
- R6: The `mode` value latched together with the accepted sample selects the response: 0 low-pass, 1 band-pass, 2 high-pass, 3 notch.
- R7: sat() clamps to the range −131072 to 131071, so the output never wraps.
- R8: `ovf` is set at a completion edge where any of the four responses was clamped. Once set, it stays high until `ovf_clr` is high at an edge. When a setting completion and `ovf_clr` fall on the same edge, `ovf` is set.
- R9: `y_out` changes only at the edge that completes a calculation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins one calculation on `x_in` when the block is idle |
| mode | input | 2 | Response select: 0 LP, 1 BP, 2 HP, 3 notch |
| coef_f | input | 18 | Signed Q1.17 frequency coefficient |
| coef_q | input | 18 | Signed Q1.17 damping coefficient (1/Q) |
| x_in | input | 18 | Signed input sample |
| ovf_clr | input | 1 | Clears the sticky clip flag |
| y_out | output | 18 | Signed selected response |
| done | output | 1 | One-cycle pulse when `y_out` is updated |
| ovf | output | 1 | Sticky flag: a response was clipped |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a clip event at a completion together with an `ovf_clr` request. The second pair is a new `start` together with the `done` cycle of the previous sample, or together with any of the busy cycles. A random phase holds `ovf_clr` and `start` high on a large share of cycles while a strongly driven input keeps clipping. This makes both pairs coincide many times. A behavioural model that counts busy edges and updates the clip flag on a set-first rule judges every cycle of `y_out`, `done` and `ovf`. The same model judges the ignored strobes during the busy edges.

// File: rtl/svf_pkg.sv
// Package: shared encodings for the state variable filter.
// Assumes: two-bit mode select and four sequencer phases.
package svf_pkg;

    // Response selected onto the output (encoding is visible at the port).
    typedef enum logic [1:0] {
        MODE_LP    = 2'd0,
        MODE_BP    = 2'd1,
        MODE_HP    = 2'd2,
        MODE_NOTCH = 2'd3
    } svf_mode_e;

    // Step of the per-sample multiplier schedule.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HP   = 2'd1,
        PH_BP   = 2'd2,
        PH_LP   = 2'd3
    } svf_phase_e;

endpackage

// File: rtl/svf_sat.sv
// Module: svf_sat
// Clamps a wide signed value into a narrower signed range and reports
// whether clamping took place. Purely combinational.
// Assumes: IW > OW and IW <= 64.
module svf_sat #(
    parameter int IW = 40,
    parameter int OW = 18
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout,
    output logic                 clip
);
    localparam logic signed [IW-1:0] MAXV = IW'((64'sd1 <<< (OW-1)) - 64'sd1);
    localparam logic signed [IW-1:0] MINV = IW'(-(64'sd1 <<< (OW-1)));

    // Compare against the limits and pick the clamped or passed value.
    always_comb begin
        if (din > MAXV) begin
            dout = MAXV[OW-1:0];
            clip = 1'b1;
        end else if (din < MINV) begin
            dout = MINV[OW-1:0];
            clip = 1'b1;
        end else begin
            dout = din[OW-1:0];
            clip = 1'b0;
        end
    end
endmodule

// File: rtl/svf_sequencer.sv
// Module: svf_sequencer
// Walks the three multiplier steps of one sample after an accepted start
// and pulses done after the last one.
// Assumes: start is a level sampled at each edge; it is ignored unless idle.
module svf_sequencer
    import svf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output svf_phase_e phase,
    output logic       accept,
    output logic       done
);
    // A new sample is only taken while no calculation is running.
    assign accept = start && (phase == PH_IDLE);

    // Advance the step register and register the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            done <= (phase == PH_LP);
            unique case (phase)
                PH_IDLE: if (accept) phase <= PH_HP;
                PH_HP:   phase <= PH_BP;
                PH_BP:   phase <= PH_LP;
                PH_LP:   phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: done follows the final step and nothing else.
    assert_done_after_lp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(phase == PH_LP));

    // R2/R3: once running, steps proceed in order whatever start does.
    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HP) |=> (phase == PH_BP));
endmodule

// File: rtl/svf_multiplier.sv
// Module: svf_multiplier
// The single shared signed multiplier with registered operands A and B.
// The product is combinational from the registered operands, so a product
// loaded in one step is used in the next step.
// Assumes: operands change only when load is high.
module svf_multiplier #(
    parameter int DW = 18,
    localparam int PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [DW-1:0] a_in,
    input  logic signed [DW-1:0] b_in,
    output logic signed [PW-1:0] prod
);
    logic signed [DW-1:0] op_a;
    logic signed [DW-1:0] op_b;

    // Capture the operands of the current step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
        end else if (load) begin
            op_a <= a_in;
            op_b <= b_in;
        end
    end

    // Full-width signed product of the held operands.
    assign prod = op_a * op_b;
endmodule

// File: rtl/svf_outstage.sv
// Module: svf_outstage
// Forms the four responses from the integrator values and the high-pass
// register, clamps them, selects one for the output and keeps the sticky
// clip flag.
// Assumes: capture is high only at the last step of a sample.
module svf_outstage
    import svf_pkg::*;
#(
    parameter int DW    = 18,
    parameter int ACC_W = 40,
    parameter int FRAC  = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  svf_mode_e               mode,
    input  logic signed [ACC_W-1:0] lp_acc,
    input  logic signed [ACC_W-1:0] bp_acc,
    input  logic signed [DW-1:0]    hp_val,
    input  logic                    hp_clip,
    input  logic                    ovf_clr,
    output logic signed [DW-1:0]    y_out,
    output logic                    ovf
);
    logic signed [ACC_W-1:0] lp_s;
    logic signed [ACC_W-1:0] bp_s;
    logic signed [ACC_W-1:0] notch_s;
    logic signed [DW-1:0]    lp_v;
    logic signed [DW-1:0]    bp_v;
    logic signed [DW-1:0]    notch_v;
    logic                    lp_c;
    logic                    bp_c;
    logic                    notch_c;
    logic signed [DW-1:0]    sel_v;
    logic                    set_now;

    // Scale the integrators back to sample units; notch adds LP and HP.
    assign lp_s    = lp_acc >>> FRAC;
    assign bp_s    = bp_acc >>> FRAC;
    assign notch_s = lp_s + {{(ACC_W-DW){hp_val[DW-1]}}, hp_val};

    svf_sat #(.IW(ACC_W), .OW(DW)) u_sat_lp    (.din(lp_s),    .dout(lp_v),    .clip(lp_c));
    svf_sat #(.IW(ACC_W), .OW(DW)) u_sat_bp    (.din(bp_s),    .dout(bp_v),    .clip(bp_c));
    svf_sat #(.IW(ACC_W), .OW(DW)) u_sat_notch (.din(notch_s), .dout(notch_v), .clip(notch_c));

    // Response mux driven by the mode latched with the sample.
    always_comb begin
        unique case (mode)
            MODE_LP:    sel_v = lp_v;
            MODE_BP:    sel_v = bp_v;
            MODE_HP:    sel_v = hp_val;
            MODE_NOTCH: sel_v = notch_v;
            default:    sel_v = lp_v;
        endcase
    end

    // Any clamped response at completion raises the flag.
    assign set_now = capture && (lp_c || bp_c || notch_c || hp_clip);

    // Output register and sticky flag; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out <= '0;
            ovf   <= 1'b0;
        end else begin
            if (capture) y_out <= sel_v;
            if (set_now)      ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    // R8: flag holds until a clear request.
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R8: a clear without a simultaneous clip empties the flag.
    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !set_now) |=> !ovf);

    // R9: output only moves on completion.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(y_out));
endmodule

// File: rtl/svf_filter.sv
// Module: svf_filter (top)
// State variable filter with one time-shared multiplier. Step schedule per
// sample: on accept load q*bp_old; HP step forms hp and loads f*hp; BP step
// updates z1 and loads f*bp; LP step updates z2 and registers the output.
// Assumes: coef_f and coef_q are stable while a calculation runs.
module svf_filter
    import svf_pkg::*;
#(
    parameter int DW       = 18,
    parameter int ACC_W    = 40,
    parameter int IN_SHIFT = 18,
    parameter int FRAC     = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           mode,
    input  logic signed [DW-1:0] coef_f,
    input  logic signed [DW-1:0] coef_q,
    input  logic signed [DW-1:0] x_in,
    input  logic                 ovf_clr,
    output logic signed [DW-1:0] y_out,
    output logic                 done,
    output logic                 ovf
);
    localparam int PW = 2 * DW;

    svf_phase_e              phase;
    logic                    accept;
    logic                    mul_load;
    logic signed [DW-1:0]    mul_a;
    logic signed [DW-1:0]    mul_b;
    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [DW-1:0]    x_q;
    svf_mode_e               mode_q;
    logic signed [ACC_W-1:0] z1;
    logic signed [ACC_W-1:0] z2;
    logic signed [DW-1:0]    hp_q;
    logic                    hp_clip_q;
    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] hp_acc;
    logic signed [ACC_W-1:0] hp_shift;
    logic signed [ACC_W-1:0] z1_sum;
    logic signed [ACC_W-1:0] z2_sum;
    logic signed [ACC_W-1:0] bp_old_s;
    logic signed [ACC_W-1:0] bp_new_s;
    logic signed [DW-1:0]    hp_sat;
    logic signed [DW-1:0]    bp_old_sat;
    logic signed [DW-1:0]    bp_new_sat;
    logic                    hp_c;
    logic                    bp_old_c;
    logic                    bp_new_c;

    svf_sequencer u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .phase  (phase),
        .accept (accept),
        .done   (done)
    );

    svf_multiplier #(.DW(DW)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mul_load),
        .a_in  (mul_a),
        .b_in  (mul_b),
        .prod  (prod)
    );

    // Widen the product and the sample to accumulator width.
    assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
    assign x_ext    = {{(ACC_W-DW){x_q[DW-1]}}, x_q};

    // High-pass: scaled input minus damping product minus low-pass state.
    assign hp_acc   = (x_ext <<< IN_SHIFT) - prod_ext - z2;
    assign hp_shift = hp_acc >>> FRAC;

    // Integrator sums that use the product of the previous step.
    assign z1_sum   = z1 + prod_ext;
    assign z2_sum   = z2 + prod_ext;
    assign bp_old_s = z1 >>> FRAC;
    assign bp_new_s = z1_sum >>> FRAC;

    svf_sat #(.IW(ACC_W), .OW(DW)) u_sat_hp    (.din(hp_shift), .dout(hp_sat),     .clip(hp_c));
    svf_sat #(.IW(ACC_W), .OW(DW)) u_sat_bpold (.din(bp_old_s), .dout(bp_old_sat), .clip(bp_old_c));
    svf_sat #(.IW(ACC_W), .OW(DW)) u_sat_bpnew (.din(bp_new_s), .dout(bp_new_sat), .clip(bp_new_c));

    // Operand schedule of the shared multiplier for each step.
    always_comb begin
        mul_load = 1'b0;
        mul_a    = coef_f;
        mul_b    = '0;
        unique case (phase)
            PH_IDLE: begin mul_load = accept; mul_a = coef_q; mul_b = bp_old_sat; end
            PH_HP:   begin mul_load = 1'b1;   mul_a = coef_f; mul_b = hp_sat;     end
            PH_BP:   begin mul_load = 1'b1;   mul_a = coef_f; mul_b = bp_new_sat; end
            default: begin mul_load = 1'b0;   mul_a = coef_f; mul_b = '0;         end
        endcase
    end

    // Sample latch, high-pass register and integrator state updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q       <= '0;
            mode_q    <= MODE_LP;
            z1        <= '0;
            z2        <= '0;
            hp_q      <= '0;
            hp_clip_q <= 1'b0;
        end else begin
            if (accept) begin
                x_q    <= x_in;
                mode_q <= svf_mode_e'(mode);
            end
            if (phase == PH_HP) begin
                hp_q      <= hp_sat;
                hp_clip_q <= hp_c;
            end
            if (phase == PH_BP) z1 <= z1_sum;
            if (phase == PH_LP) z2 <= z2_sum;
        end
    end

    svf_outstage #(.DW(DW), .ACC_W(ACC_W), .FRAC(FRAC)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (phase == PH_LP),
        .mode    (mode_q),
        .lp_acc  (z2_sum),
        .bp_acc  (z1),
        .hp_val  (hp_q),
        .hp_clip (hp_clip_q),
        .ovf_clr (ovf_clr),
        .y_out   (y_out),
        .ovf     (ovf)
    );

    // R3: a strobe during a running calculation leaves the latched sample alone.
    assert_busy_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && phase != PH_IDLE) |=> $stable(x_q) && $stable(mode_q));

    // R5: band-pass state moves only in its own step.
    assert_z1_only_bp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_BP) |=> $stable(z1));

    // R5: low-pass state moves only in its own step.
    assert_z2_only_lp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_LP) |=> $stable(z2));
endmodule

// File: tb/svf_filter_test.sv
// Bench: behavioural per-cycle model of the filter compared on every clock.
module svf_filter_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         mode = 2'd0;
    logic signed [17:0] coef_f = 18'sd0;
    logic signed [17:0] coef_q = 18'sd0;
    logic signed [17:0] x_in = 18'sd0;
    logic               ovf_clr = 1'b0;
    logic signed [17:0] y_out;
    logic               done;
    logic               ovf;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Model state
    longint m_z1 = 0, m_z2 = 0, m_y = 0;
    int     m_busy = 0;
    bit     m_done = 0, m_ovf = 0;
    longint m_x = 0;
    int     m_mode = 0;
    longint p_y = 0;
    bit     p_clip = 0;

    svf_filter uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .coef_f(coef_f), .coef_q(coef_q), .x_in(x_in), .ovf_clr(ovf_clr),
        .y_out(y_out), .done(done), .ovf(ovf)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic longint wrap40(longint v);
        logic [39:0] t;
        t = v[39:0];
        return longint'($signed(t));
    endfunction

    function automatic longint sat18(longint v, output bit c);
        c = 1'b0;
        if (v > 131071)  begin c = 1'b1; return 131071;  end
        if (v < -131072) begin c = 1'b1; return -131072; end
        return v;
    endfunction

    // Full calculation of one sample from the requirement equations.
    task automatic model_calc();
        bit c_o, c_h, c_b1, c_l, c_b, c_n;
        longint f, q, bp_old, hp, bpn, lp, bp, notch;
        f = longint'(coef_f);
        q = longint'(coef_q);
        bp_old = sat18(m_z1 >>> 17, c_o);
        hp     = sat18(wrap40((m_x <<< 18) - q * bp_old - m_z2) >>> 17, c_h);
        m_z1   = wrap40(m_z1 + f * hp);
        bpn    = sat18(m_z1 >>> 17, c_b1);
        m_z2   = wrap40(m_z2 + f * bpn);
        lp     = sat18(m_z2 >>> 17, c_l);
        bp     = sat18(m_z1 >>> 17, c_b);
        notch  = sat18((m_z2 >>> 17) + hp, c_n);
        case (m_mode)
            0: p_y = lp;
            1: p_y = bp;
            2: p_y = hp;
            default: p_y = notch;
        endcase
        p_clip = c_h | c_l | c_b | c_n;
    endtask

    // Model update at each edge, from the inputs driven at the last negedge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_z1 = 0; m_z2 = 0; m_y = 0; m_busy = 0; m_done = 0; m_ovf = 0;
        end else begin
            m_done = 0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    model_calc();
                    m_y = p_y;
                    m_done = 1;
                end
            end else if (start) begin
                m_x = longint'(x_in);
                m_mode = int'(mode);
                m_busy = 3;
            end
            if (m_done && p_clip) m_ovf = 1;
            else if (ovf_clr)     m_ovf = 0;
        end
    end

    // Compare all outputs away from the active edge.
    always @(negedge clk) begin
        checks++;
        if (longint'(y_out) !== m_y) begin
            errors++;
            $display("FAIL %s y_out actual=%0d expected=%0d", cur_req, y_out, m_y);
        end
        checks++;
        if (done !== m_done) begin
            errors++;
            $display("FAIL %s done actual=%0d expected=%0d", cur_req, done, m_done);
        end
        checks++;
        if (ovf !== m_ovf) begin
            errors++;
            $display("FAIL %s ovf actual=%0d expected=%0d", cur_req, ovf, m_ovf);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(int n);
        start = 1'b0;
        ovf_clr = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // One sample with start held only in its accept cycle.
    task automatic one_sample(logic signed [17:0] x, logic [1:0] m);
        @(negedge clk);
        start = 1'b1; x_in = x; mode = m;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Random traffic: start, mode, sample and clear chosen each cycle.
    task automatic random_run(int n, int start_pct, int clr_pct, int xmax);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start   = ($urandom_range(99) < start_pct);
            ovf_clr = ($urandom_range(99) < clr_pct);
            mode    = 2'($urandom_range(3));
            x_in    = 18'($signed($urandom_range(2 * xmax)) - xmax);
        end
        idle(6);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R4 R5 R6: step response in each mode, Q = 1, mild cutoff
        coef_f = 18'sd8235; coef_q = 18'sd131071;
        cur_req = "R4 R5 R6";
        for (int k = 0; k < 4; k++)
            for (int s = 0; s < 12; s++) one_sample(18'sd10000, 2'(k));
        for (int s = 0; s < 12; s++) one_sample(-18'sd20000, 2'(s % 4));

        // R4 R5: higher Q and alternating input
        coef_f = 18'sd30000; coef_q = 18'sd20000;
        idle(2);
        for (int s = 0; s < 40; s++) one_sample((s % 2) ? 18'sd15000 : -18'sd15000, 2'(s % 4));

        // R2 R3 R9: dense strobes, back-to-back and during busy, moving mode/x
        cur_req = "R2 R3 R9";
        coef_f = 18'sd12000; coef_q = 18'sd60000;
        idle(2);
        random_run(2000, 70, 0, 20000);

        // R7 R8: strong drive clips, clears coincide with clip completions
        cur_req = "R7 R8";
        coef_f = 18'sd90000; coef_q = 18'sd5000;
        idle(2);
        random_run(3000, 60, 40, 131072);
        for (int s = 0; s < 20; s++) one_sample(18'sd131071, 2'd3);
        cur_req = "R8";
        idle(3);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        idle(3);

        // R1: reset in the middle of a calculation clears states and outputs
        cur_req = "R1";
        @(negedge clk); start = 1'b1; x_in = 18'sd5000;
        @(negedge clk); start = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        coef_f = 18'sd8235; coef_q = 18'sd131071;
        for (int s = 0; s < 4; s++) one_sample(18'sd0, 2'(s));
        idle(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule